// File: doc/BRIEF.md
# Dual Segment Counter with Wrap Limits

This block steers a 16-bit data bus across the four 16-bit quarters of a 64-bit internal word. It holds two independent 2-bit counters. One picks the quarter written on the next data-write cycle. The other picks the quarter sourced on the next data-read cycle. Each counter has a start limit, an end limit and a current value. All six fields are packed into one 16-bit control word, which can be written and read back.

A counter counts upward. Once it has reached its end limit, the next step loads its start limit. The current value may be set to any quarter, including one beyond the end limit. In that case the counter climbs to 3, rolls over to 0, and carries on until it meets the end limit, where the normal wrap to the start limit resumes. A restart command puts both current values back to their start limits.

The block keeps a foreground and a background copy of the control word. The copy select input picks the active copy. Control writes, read-back, data-cycle advances, restarts and the segment outputs all use the active copy only.

Top module: `seg_counter_pair`

## Requirements
- R1: After reset, both copies hold start 0, end 3 and current 0 for both counters, so that `ctl_rdata` reads 16'h1818 and `rd_seg` = `wr_seg` = 0 whichever copy is selected.
- R2: `ctl_wr` loads the active copy from `ctl_wdata` with this field layout: read current [1:0], read end [4:3], read start [7:6], write current [9:8], write end [12:11], write start [14:13]. `ctl_rdata` returns the active copy in the same layout.
- R3: Bits 15, 10, 5 and 2 of `ctl_rdata` are always 0, whatever was written to them.
- R4: The read counter moves only on a `data_rd_cyc` cycle and the write counter only on a `data_wr_cyc` cycle. Each holds its value on every other cycle.
- R5: On an advance where the current value differs from the end limit, the current value becomes current+1 modulo 4.
- R6: On an advance where the current value equals the end limit, the current value becomes the start limit.
- R7: A current value above the end limit steps up to 3, then to 0, then upward until it equals the end limit, and then loads the start limit.
- R8: `seg_restart` sets both current values of the active copy to their start limits and leaves the limits unchanged.
- R9: Only the copy selected by `bank_sel` (0 = foreground, 1 = background) is written, restarted, advanced or shown on `ctl_rdata`, `rd_seg` and `wr_seg`. The other copy keeps its contents.
- R10: In one cycle, `ctl_wr` takes precedence over `seg_restart`, and `seg_restart` takes precedence over data-cycle advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_sel | input | 1 | Active copy: 0 foreground, 1 background |
| ctl_wr | input | 1 | Load the active control word |
| ctl_wdata | input | 16 | Control word to load |
| seg_restart | input | 1 | Restore both current values to their start limits |
| data_wr_cyc | input | 1 | Data-write cycle; advances the write counter |
| data_rd_cyc | input | 1 | Data-read cycle; advances the read counter |
| ctl_rdata | output | 16 | Active control word, reserved bits zero |
| wr_seg | output | 2 | Quarter selected for the next data write |
| rd_seg | output | 2 | Quarter selected for the next data read |

## Verification
The assertions assume that `bank_sel` is a clean 0 or 1 at each edge. They also assume that a control write, a restart and data cycles may all arrive in the same cycle, and they take the priority order of R10 as the rule for resolving that. The stimulus draws every control input at random on each cycle, with control writes and copy changes kept rare so that long counting runs occur. This includes data reads and writes in the same cycle and restarts overlapping writes. Directed sequences place a current value above its end limit and equal to it, so that the rollover path and the end-to-start wrap are both reached.

// File: rtl/seg_counter_pair.sv
module seg_counter_pair (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bank_sel,
  input  logic        ctl_wr,
  input  logic [15:0] ctl_wdata,
  input  logic        seg_restart,
  input  logic        data_wr_cyc,
  input  logic        data_rd_cyc,
  output logic [15:0] ctl_rdata,
  output logic [1:0]  wr_seg,
  output logic [1:0]  rd_seg
);
  localparam int COPIES = 2;

  logic [1:0] rd_st [COPIES], rd_end [COPIES], rd_cur [COPIES];
  logic [1:0] wr_st [COPIES], wr_end [COPIES], wr_cur [COPIES];

  function automatic logic [1:0] advance(input logic [1:0] cur, input logic [1:0] lim_end,
                                         input logic [1:0] lim_st);
    return (cur == lim_end) ? lim_st : 2'(cur + 2'd1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < COPIES; i++) begin
        rd_st[i] <= 2'd0; rd_end[i] <= 2'd3; rd_cur[i] <= 2'd0;
        wr_st[i] <= 2'd0; wr_end[i] <= 2'd3; wr_cur[i] <= 2'd0;
      end
    end else if (ctl_wr) begin
      rd_cur[bank_sel] <= ctl_wdata[1:0];
      rd_end[bank_sel] <= ctl_wdata[4:3];
      rd_st[bank_sel]  <= ctl_wdata[7:6];
      wr_cur[bank_sel] <= ctl_wdata[9:8];
      wr_end[bank_sel] <= ctl_wdata[12:11];
      wr_st[bank_sel]  <= ctl_wdata[14:13];
    end else if (seg_restart) begin
      rd_cur[bank_sel] <= rd_st[bank_sel];
      wr_cur[bank_sel] <= wr_st[bank_sel];
    end else begin
      if (data_rd_cyc)
        rd_cur[bank_sel] <= advance(rd_cur[bank_sel], rd_end[bank_sel], rd_st[bank_sel]);
      if (data_wr_cyc)
        wr_cur[bank_sel] <= advance(wr_cur[bank_sel], wr_end[bank_sel], wr_st[bank_sel]);
    end
  end

  assign ctl_rdata = {1'b0, wr_st[bank_sel], wr_end[bank_sel], 1'b0, wr_cur[bank_sel],
                      rd_st[bank_sel], 1'b0, rd_end[bank_sel], 1'b0, rd_cur[bank_sel]};
  assign rd_seg = rd_cur[bank_sel];
  assign wr_seg = wr_cur[bank_sel];

  always_comb begin
    AST_RESERVED_ZERO: assert (!rst_n || (ctl_rdata & 16'h8424) == 16'h0000); // R3
  end

  property p_seg_outputs;
    @(posedge clk) disable iff (!rst_n) (rd_seg == ctl_rdata[1:0]) && (wr_seg == ctl_rdata[9:8]);
  endproperty
  AST_SEG_MATCHES_WORD: assert property (p_seg_outputs); // R2

  for (genvar g = 0; g < COPIES; g++) begin : g_chk
    localparam logic SEL = 1'(g);

    AST_OTHER_COPY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_sel != SEL) |=> $stable(rd_cur[g]) && $stable(wr_cur[g]) && $stable(rd_st[g])
                            && $stable(rd_end[g]) && $stable(wr_st[g]) && $stable(wr_end[g])); // R9

    AST_RD_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_wr && !seg_restart && !data_rd_cyc) |=> $stable(rd_cur[g])); // R4

    AST_WR_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_wr && !seg_restart && !data_wr_cyc) |=> $stable(wr_cur[g])); // R4

    AST_RD_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_sel == SEL && !ctl_wr && !seg_restart && data_rd_cyc && rd_cur[g] != rd_end[g])
      |=> rd_cur[g] == 2'($past(rd_cur[g]) + 2'd1)); // R5

    AST_RD_WRAP_START: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_sel == SEL && !ctl_wr && !seg_restart && data_rd_cyc && rd_cur[g] == rd_end[g])
      |=> rd_cur[g] == $past(rd_st[g])); // R6

    AST_WR_WRAP_START: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_sel == SEL && !ctl_wr && !seg_restart && data_wr_cyc && wr_cur[g] == wr_end[g])
      |=> wr_cur[g] == $past(wr_st[g])); // R6

    AST_RESTART_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_sel == SEL && !ctl_wr && seg_restart)
      |=> rd_cur[g] == $past(rd_st[g]) && wr_cur[g] == $past(wr_st[g])
          && $stable(rd_end[g]) && $stable(wr_end[g])); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_sel == SEL && ctl_wr)
      |=> rd_cur[g] == $past(ctl_wdata[1:0]) && wr_cur[g] == $past(ctl_wdata[9:8])); // R10
  end
endmodule

// File: tb/test_seg_counter_pair.sv
module test_seg_counter_pair;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bank_sel = 1'b0, ctl_wr = 1'b0, seg_restart = 1'b0, data_wr_cyc = 1'b0, data_rd_cyc = 1'b0;
  logic [15:0] ctl_wdata = 16'h0;
  logic [15:0] ctl_rdata;
  logic [1:0] wr_seg, rd_seg;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [1:0] m_rs [2], m_re [2], m_rc [2], m_ws [2], m_we [2], m_wc [2];

  seg_counter_pair i_seg_counter_pair (.*);

  always #5 clk = ~clk;

  function automatic logic [1:0] nxt(input logic [1:0] c, input logic [1:0] e, input logic [1:0] s);
    if (c == e) return s;
    return (c == 2'd3) ? 2'd0 : c + 2'd1;
  endfunction

  function automatic logic [15:0] word(input int k);
    logic [15:0] w = '0;
    w[1:0] = m_rc[k]; w[4:3] = m_re[k]; w[7:6] = m_rs[k];
    w[9:8] = m_wc[k]; w[12:11] = m_we[k]; w[14:13] = m_ws[k];
    return w;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_rs[k] = 0; m_re[k] = 3; m_rc[k] = 0; m_ws[k] = 0; m_we[k] = 3; m_wc[k] = 0;
    end
  endtask

  task automatic check(input string tag);
    int k = int'(bank_sel);
    n_cmp++;
    if (ctl_rdata !== word(k) || rd_seg !== m_rc[k] || wr_seg !== m_wc[k]) begin
      n_bad++;
      $display("FAIL %s: word=%h rd=%0d wr=%0d expected word=%h rd=%0d wr=%0d",
               tag, ctl_rdata, rd_seg, wr_seg, word(k), m_rc[k], m_wc[k]);
    end
  endtask

  task automatic cyc(input logic sel, input logic we, input logic [15:0] wd,
                     input logic rs, input logic dw, input logic dr, input string tag);
    int k = int'(sel);
    bank_sel = sel; ctl_wr = we; ctl_wdata = wd; seg_restart = rs;
    data_wr_cyc = dw; data_rd_cyc = dr;
    @(posedge clk);
    if (we) begin
      m_rc[k] = wd[1:0]; m_re[k] = wd[4:3]; m_rs[k] = wd[7:6];
      m_wc[k] = wd[9:8]; m_we[k] = wd[12:11]; m_ws[k] = wd[14:13];
    end else if (rs) begin
      m_rc[k] = m_rs[k]; m_wc[k] = m_ws[k];
    end else begin
      if (dr) m_rc[k] = nxt(m_rc[k], m_re[k], m_rs[k]);
      if (dw) m_wc[k] = nxt(m_wc[k], m_we[k], m_ws[k]);
    end
    @(negedge clk);
    ctl_wr = 1'b0; seg_restart = 1'b0; data_wr_cyc = 1'b0; data_rd_cyc = 1'b0;
    check(tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0C0F));
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reset fg");
    bank_sel = 1'b1; #1; check("R1 reset bg");
    bank_sel = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    cyc(0, 1, 16'hFFFF, 0, 0, 0, "R2 R3 all ones");
    cyc(0, 1, 16'h0053, 0, 0, 0, "R2 rd cur3 end2 st1");
    cyc(0, 0, 0, 0, 0, 1, "R7 3 rolls to 0");
    cyc(0, 0, 0, 0, 0, 1, "R5 0 to 1");
    cyc(0, 0, 0, 0, 0, 1, "R5 1 to 2");
    cyc(0, 0, 0, 0, 0, 1, "R6 end to start");
    cyc(0, 0, 0, 0, 0, 0, "R4 idle hold");
    cyc(0, 0, 0, 0, 1, 0, "R4 write only");
    cyc(1, 0, 0, 0, 0, 0, "R9 bg untouched");
    cyc(1, 0, 0, 0, 1, 1, "R9 bg advances");
    cyc(0, 0, 0, 0, 0, 0, "R9 fg kept");
    cyc(0, 0, 0, 1, 0, 0, "R8 restart");
    cyc(0, 1, 16'h2A5B, 1, 1, 1, "R10 write beats restart");
    cyc(0, 0, 0, 1, 1, 1, "R10 restart beats advance");
    cyc(1, 1, 16'h3F00, 0, 0, 0, "R2 bg write");
    cyc(1, 0, 0, 0, 1, 0, "R6 wr end to start");

    for (int n = 0; n < 4000; n++) begin
      logic sel, we, rs;
      logic [15:0] wd;
      sel = ($urandom % 16) == 0 ? ~bank_sel : bank_sel;
      we  = ($urandom % 20) == 0;
      rs  = ($urandom % 25) == 0;
      wd  = 16'($urandom);
      cyc(sel, we, wd, rs, 1'($urandom), 1'($urandom), "R4 R5 R6 R7 R8 R9 R10 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); end
    join_any
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: done=0 expected done=1");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule